// File: doc/BRIEF.md
# Four-Channel Bus-Mapped Interval Timer

This block gives a processor four independent up-counting interval timers behind one simple synchronous read/write port. Each channel sits in its own 64-byte address window. Software controls it through write-only command addresses: one clears the count, one starts the channel, one stops it. A mode word picks between repeating operation and a single expiry.

Software can read a packed status byte, the live count and the terminal count. It arms the channel interrupt through an enable word and clears a pending event through an acknowledge word. A single clock-request bit, placed above the channel windows, gates counting in all channels at once.

Each channel advances only on cycles where its own tick-enable input is high. Dividing the clock down for each channel's tick rate happens outside the block, so one fast clock can serve channels that run at very different rates. Each channel drives its own interrupt line.

Top module: `mmio_interval_timer`

## Requirements
- R1: Channel n occupies byte addresses n*0x40 to n*0x40+0x3F. Inside a window, reads return status at offset 0x10, the current count at 0x14 and the terminal count at 0x18. Offsets 0x00, 0x04, 0x08, 0x0C, 0x1C and 0x20 are write-only and read as zero. The clock-request bit is bit 0 at address 0x100 and can be read back. Every other address reads zero.
- R2: After the synchronous reset every channel is in this state: count 0, terminal count all ones, repeating mode, interrupt disabled, stopped, nothing pending. Each status reads 0x01, the clock-request bit is 0 and every interrupt line is low.
- R3: A write of any data to offset 0x04 starts a channel, and a write of any data to offset 0x08 stops it. Stopping freezes the count at its present value.
- R4: A channel's count goes up by exactly one on each clock in which three things hold together: its tick-enable input is high, the channel is running, and the clock-request bit is 1. In every other clock the count holds.
- R5: On an advancing tick where the count equals the terminal count, the pending flag sets. In repeating mode the count then goes back to 0 and keeps running, so events come every terminal count + 1 ticks.
- R6: A write to offset 0x0C with bit 0 = 1 selects single-expiry mode, and bit 0 = 0 selects repeating mode. In single-expiry mode, the terminal-count tick leaves the count at the terminal value, stops the channel and returns its state to idle.
- R7: The status byte packs the channel as follows. Bits [3:0] give the state, 1 for idle and 2 for running. Bit 4 is set while the channel runs, bit 5 in single-expiry mode, bit 6 while the interrupt is enabled and bit 7 while an event is pending. Bits [31:8] read zero.
- R8: A write to offset 0x00 clears the count and the pending flag. It leaves the terminal count, the mode, the interrupt enable and the run state as they were.
- R9: Bit 0 of offset 0x1C enables the interrupt. A channel's interrupt line is high exactly while it has an event pending and its interrupt is enabled.
- R10: A write to offset 0x20 with bit 7 set clears the pending flag, and with bit 7 clear it does nothing. If an acknowledge and a terminal-count tick fall in the same clock, the flag stays set.
- R11: With the terminal count at all ones in repeating mode, the counter runs free and wraps from its maximum to 0.
- R12: Commands, ticks and events of one channel have no effect on any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | ADDR_W (9) | Byte address, shared by reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| tick_en | input | NUM_CH (4) | Per-channel count-advance qualifier |
| irq | output | NUM_CH (4) | Per-channel interrupt, pending AND enabled |

## Verification
The bench builds the block with four channels and an 8-bit counter width, leaving address width and window size at their defaults. The narrow counter makes the all-ones terminal count reachable in a few hundred ticks, so the free-running wrap from maximum to zero is checked directly rather than argued. Four channels cover every window, the clock-request word just above them, and isolation between neighbours. The acknowledge and terminal-tick collision is driven in a single clock.

// File: rtl/ivt_pkg.sv
`timescale 1ns/1ps
package ivt_pkg;

    localparam int BUS_W = 32;
    localparam int OFS_BITS = 6;

    // Register offsets inside one channel window
    localparam logic [OFS_BITS-1:0] OFS_CLR    = 6'h00;
    localparam logic [OFS_BITS-1:0] OFS_START  = 6'h04;
    localparam logic [OFS_BITS-1:0] OFS_STOP   = 6'h08;
    localparam logic [OFS_BITS-1:0] OFS_MODE   = 6'h0C;
    localparam logic [OFS_BITS-1:0] OFS_STAT   = 6'h10;
    localparam logic [OFS_BITS-1:0] OFS_COUNT  = 6'h14;
    localparam logic [OFS_BITS-1:0] OFS_LIMIT  = 6'h18;
    localparam logic [OFS_BITS-1:0] OFS_IRQEN  = 6'h1C;
    localparam logic [OFS_BITS-1:0] OFS_IRQACK = 6'h20;

    localparam int ACK_BIT = 7;

    typedef enum logic [3:0] {
        CH_IDLE    = 4'd1,
        CH_RUNNING = 4'd2
    } ch_state_e;

    // Per-channel write strobes produced by the decoder
    typedef struct packed {
        logic clr;
        logic start;
        logic stop;
        logic mode_wr;
        logic limit_wr;
        logic irqen_wr;
        logic ack_wr;
    } ch_cmd_t;

    // Status byte, MSB first: pending, irq enable, single, running, state
    typedef struct packed {
        logic      pend;
        logic      irq_on;
        logic      single;
        logic      running;
        ch_state_e state;
    } ch_status_t;

    function automatic ch_state_e state_of(input logic running);
        return running ? CH_RUNNING : CH_IDLE;
    endfunction

endpackage

// File: rtl/ivt_decode.sv
`timescale 1ns/1ps
module ivt_decode
    import ivt_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int ADDR_W    = 9,
    parameter int WIN_BYTES = 64
) (
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         addr,
    output ch_cmd_t [NUM_CH-1:0]      cmd,
    output logic                      creq_wr,
    output logic                      in_chan,
    output logic                      at_creq,
    output logic [ADDR_W-$clog2(WIN_BYTES)-1:0] win_idx,
    output logic [$clog2(WIN_BYTES)-1:0]        win_ofs
);
    localparam int OFS_W = $clog2(WIN_BYTES);
    localparam int IDX_W = ADDR_W - OFS_W;
    localparam logic [ADDR_W-1:0] CREQ_ADDR = ADDR_W'(NUM_CH * WIN_BYTES);

    assign win_idx = addr[ADDR_W-1:OFS_W];
    assign win_ofs = addr[OFS_W-1:0];
    assign in_chan = addr < CREQ_ADDR;
    assign at_creq = addr == CREQ_ADDR;
    assign creq_wr = wr_en && at_creq;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
        logic hit;
        assign hit = wr_en && in_chan && (win_idx == IDX_W'(i));
        assign cmd[i] = '{
            clr:      hit && (win_ofs == OFS_W'(OFS_CLR)),
            start:    hit && (win_ofs == OFS_W'(OFS_START)),
            stop:     hit && (win_ofs == OFS_W'(OFS_STOP)),
            mode_wr:  hit && (win_ofs == OFS_W'(OFS_MODE)),
            limit_wr: hit && (win_ofs == OFS_W'(OFS_LIMIT)),
            irqen_wr: hit && (win_ofs == OFS_W'(OFS_IRQEN)),
            ack_wr:   hit && (win_ofs == OFS_W'(OFS_IRQACK))
        };
    end

    always_comb begin
        assert ($countones(cmd) <= 1)
            else $error("assert_one_strobe_R12: several channel strobes at once");
    end

endmodule

// File: rtl/ivt_channel.sv
`timescale 1ns/1ps
module ivt_channel
    import ivt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  ch_cmd_t           cmd,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              tick,
    input  logic              clk_req,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  limit,
    output ch_status_t        status,
    output logic              irq
);
    logic running, single, irq_on, pend;
    logic advance, at_limit;
    logic unused_wdata;

    assign unused_wdata = ^wdata;
    assign advance  = tick && running && clk_req;
    assign at_limit = advance && (count == limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            limit   <= '1;
            single  <= 1'b0;
            irq_on  <= 1'b0;
            running <= 1'b0;
            pend    <= 1'b0;
        end else begin
            if (cmd.limit_wr) limit  <= wdata[CNT_W-1:0];
            if (cmd.mode_wr)  single <= wdata[0];
            if (cmd.irqen_wr) irq_on <= wdata[0];

            if (cmd.stop)                 running <= 1'b0;
            else if (cmd.start)           running <= 1'b1;
            else if (at_limit && single)  running <= 1'b0;

            if (cmd.clr)                  count <= '0;
            else if (at_limit) begin
                if (!single)              count <= '0;
            end else if (advance)         count <= count + 1'b1;

            if (cmd.clr)                  pend <= 1'b0;
            else if (at_limit)            pend <= 1'b1;
            else if (cmd.ack_wr && wdata[ACK_BIT]) pend <= 1'b0;
        end
    end

    assign status = '{
        pend:    pend,
        irq_on:  irq_on,
        single:  single,
        running: running,
        state:   state_of(running)
    };
    assign irq = pend && irq_on;

    // R4: no advance and no clear means the count holds
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!advance && !cmd.clr) |=> $stable(count));

    // R4: an advance short of the limit steps by one
    assert_step_R4: assert property (@(posedge clk) disable iff (rst)
        (advance && !at_limit && !cmd.clr) |=> (count == CNT_W'($past(count) + 1'b1)));

    // R5: reaching the limit raises the pending flag
    assert_pend_R5: assert property (@(posedge clk) disable iff (rst)
        (at_limit && !cmd.clr) |=> status.pend);

    // R6: single-expiry stops with the count parked
    assert_single_stop_R6: assert property (@(posedge clk) disable iff (rst)
        (at_limit && single && !cmd.clr && !cmd.start) |=>
        (!status.running && $stable(count)));

    // R8: clear command empties count and pending
    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        cmd.clr |=> (count == '0 && !status.pend));

    // R10: acknowledge without a coincident event clears pending
    assert_ack_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd.ack_wr && wdata[ACK_BIT] && !at_limit) |=> !irq);

endmodule

// File: rtl/ivt_readback.sv
`timescale 1ns/1ps
module ivt_readback
    import ivt_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32,
    parameter int IDX_W  = 3,
    parameter int OFS_W  = 6
) (
    input  logic [NUM_CH-1:0][CNT_W-1:0] count_all,
    input  logic [NUM_CH-1:0][CNT_W-1:0] limit_all,
    input  ch_status_t [NUM_CH-1:0]      stat_all,
    input  logic                         clk_req,
    input  logic                         in_chan,
    input  logic                         at_creq,
    input  logic [IDX_W-1:0]             win_idx,
    input  logic [OFS_W-1:0]             win_ofs,
    output logic [BUS_W-1:0]             rdata
);
    always_comb begin
        rdata = '0;
        if (at_creq) begin
            rdata[0] = clk_req;
        end else if (in_chan) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (win_idx == IDX_W'(i)) begin
                    if (win_ofs == OFS_W'(OFS_STAT))
                        rdata = BUS_W'(stat_all[i]);
                    else if (win_ofs == OFS_W'(OFS_COUNT))
                        rdata = BUS_W'(count_all[i]);
                    else if (win_ofs == OFS_W'(OFS_LIMIT))
                        rdata = BUS_W'(limit_all[i]);
                end
            end
        end
    end
endmodule

// File: rtl/mmio_interval_timer.sv
`timescale 1ns/1ps
module mmio_interval_timer
    import ivt_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int CNT_W     = 32,
    parameter int ADDR_W    = 9,
    parameter int WIN_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    input  logic [NUM_CH-1:0] tick_en,
    output logic [NUM_CH-1:0] irq
);
    localparam int OFS_W = $clog2(WIN_BYTES);
    localparam int IDX_W = ADDR_W - OFS_W;

    ch_cmd_t [NUM_CH-1:0]          cmd;
    logic                          creq_wr, in_chan, at_creq;
    logic [IDX_W-1:0]              win_idx;
    logic [OFS_W-1:0]              win_ofs;
    logic                          clk_req;
    logic [NUM_CH-1:0][CNT_W-1:0]  count_all, limit_all;
    ch_status_t [NUM_CH-1:0]       stat_all;

    ivt_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES)) u_decode (
        .wr_en(wr_en), .addr(addr), .cmd(cmd), .creq_wr(creq_wr),
        .in_chan(in_chan), .at_creq(at_creq), .win_idx(win_idx), .win_ofs(win_ofs)
    );

    always_ff @(posedge clk) begin
        if (rst)          clk_req <= 1'b0;
        else if (creq_wr) clk_req <= wdata[0];
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        ivt_channel #(.CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst(rst), .cmd(cmd[i]), .wdata(wdata),
            .tick(tick_en[i]), .clk_req(clk_req),
            .count(count_all[i]), .limit(limit_all[i]),
            .status(stat_all[i]), .irq(irq[i])
        );
    end

    ivt_readback #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_readback (
        .count_all(count_all), .limit_all(limit_all), .stat_all(stat_all),
        .clk_req(clk_req), .in_chan(in_chan), .at_creq(at_creq),
        .win_idx(win_idx), .win_ofs(win_ofs), .rdata(rdata)
    );

    // R4: with clock request off no channel may change its count
    assert_gate_R4: assert property (@(posedge clk) disable iff (rst)
        (!clk_req && !creq_wr && wr_en == 1'b0) |=> $stable(count_all));

endmodule

// File: tb/mmio_interval_timer_tb.sv
`timescale 1ns/1ps
module mmio_interval_timer_tb;
    localparam int NUM_CH = 4;
    localparam int CNT_W  = 8;
    localparam int ADDR_W = 9;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic [NUM_CH-1:0] tick_en = '0;
    logic [NUM_CH-1:0] irq;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    mmio_interval_timer #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .tick_en(tick_en), .irq(irq)
    );

    function automatic logic [ADDR_W-1:0] ra(input int ch, input int ofs);
        return ADDR_W'(ch * 64 + ofs);
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic ticks(input int ch, input int n);
        @(negedge clk);
        tick_en[ch] = 1'b1;
        repeat (n) @(negedge clk);
        tick_en[ch] = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        for (int c = 0; c < NUM_CH; c++) begin
            rd(ra(c, 'h10), d); check("R2 status after reset", d, 32'h01);
            rd(ra(c, 'h14), d); check("R2 count after reset", d, 32'h0);
            rd(ra(c, 'h18), d); check("R2 limit after reset", d, 32'hFF);
        end
        rd(9'h100, d); check("R2 clock request after reset", d, 32'h0);
        check("R2 irq after reset", 32'(irq), 32'h0);
    endtask

    task automatic t_map();
        logic [31:0] d;
        wr(ra(1, 'h18), 32'h5A);
        rd(ra(1, 'h18), d); check("R1 limit readback", d, 32'h5A);
        rd(ra(1, 'h00), d); check("R1 clear offset reads zero", d, 32'h0);
        rd(ra(1, 'h04), d); check("R1 start offset reads zero", d, 32'h0);
        rd(ra(1, 'h1C), d); check("R1 irq-enable offset reads zero", d, 32'h0);
        rd(ra(1, 'h20), d); check("R1 ack offset reads zero", d, 32'h0);
        rd(ra(1, 'h24), d); check("R1 unmapped offset reads zero", d, 32'h0);
        wr(9'h100, 32'h1);
        rd(9'h100, d); check("R1 clock request readback", d, 32'h1);
        rd(9'h104, d); check("R1 address above map reads zero", d, 32'h0);
        rd(ra(0, 'h18), d); check("R12 neighbour limit untouched", d, 32'hFF);
    endtask

    task automatic t_start_stop();
        logic [31:0] d;
        wr(ra(0, 'h04), 32'hDEAD_BEEF);
        rd(ra(0, 'h10), d); check("R3 R7 status running", d, 32'h12);
        ticks(0, 5);
        rd(ra(0, 'h14), d); check("R4 count after 5 ticks", d, 32'h5);
        wr(ra(0, 'h08), 32'h1234);
        rd(ra(0, 'h10), d); check("R3 status after stop", d, 32'h01);
        ticks(0, 3);
        rd(ra(0, 'h14), d); check("R3 stopped count frozen", d, 32'h5);
        ticks(1, 4);
        rd(ra(1, 'h14), d); check("R4 ticks ignored while stopped", d, 32'h0);
    endtask

    task automatic t_clock_gate();
        logic [31:0] d;
        wr(9'h100, 32'h0);
        wr(ra(2, 'h04), 32'h0);
        ticks(2, 4);
        rd(ra(2, 'h14), d); check("R4 no count without clock request", d, 32'h0);
        wr(9'h100, 32'h1);
        ticks(2, 4);
        rd(ra(2, 'h14), d); check("R4 count with clock request", d, 32'h4);
        rd(ra(0, 'h14), d); check("R12 channel 0 unaffected", d, 32'h5);
        wr(ra(2, 'h08), 32'h0);
    endtask

    task automatic t_clear_cmd();
        logic [31:0] d;
        wr(ra(0, 'h18), 32'd10);
        wr(ra(0, 'h0C), 32'h1);
        wr(ra(0, 'h1C), 32'h1);
        wr(ra(0, 'h00), 32'hFFFF_FFFF);
        rd(ra(0, 'h14), d); check("R8 count cleared", d, 32'h0);
        rd(ra(0, 'h10), d); check("R8 R7 mode and enable kept", d, 32'h61);
        rd(ra(0, 'h18), d); check("R8 limit kept", d, 32'd10);
    endtask

    task automatic t_repeat();
        logic [31:0] d;
        wr(ra(3, 'h18), 32'd3);
        wr(ra(3, 'h1C), 32'h1);
        wr(ra(3, 'h04), 32'h0);
        ticks(3, 3);
        rd(ra(3, 'h14), d); check("R5 count at limit", d, 32'h3);
        rd(ra(3, 'h10), d); check("R5 not pending before limit tick", d, 32'h52);
        ticks(3, 1);
        rd(ra(3, 'h14), d); check("R5 count back to zero", d, 32'h0);
        rd(ra(3, 'h10), d); check("R5 R7 pending status", d, 32'hD2);
        check("R9 irq with pending and enabled", 32'(irq), 32'h8);
        wr(ra(3, 'h20), 32'h7F);
        rd(ra(3, 'h10), d); check("R10 ack without bit 7 ignored", d, 32'hD2);
        wr(ra(3, 'h20), 32'h80);
        rd(ra(3, 'h10), d); check("R10 ack clears pending", d, 32'h52);
        check("R9 irq low after ack", 32'(irq), 32'h0);
        wr(ra(3, 'h1C), 32'h0);
        ticks(3, 4);
        rd(ra(3, 'h10), d); check("R5 second event after period", d, 32'h92);
        check("R9 irq masked when disabled", 32'(irq), 32'h0);
        wr(ra(3, 'h1C), 32'h1);
        check("R9 irq after enable", 32'(irq), 32'h8);
        wr(ra(3, 'h20), 32'h80);
        ticks(3, 3);
        @(negedge clk);
        tick_en[3] = 1'b1; wr_en = 1'b1; addr = ra(3, 'h20); wdata = 32'h80;
        @(negedge clk);
        tick_en[3] = 1'b0; wr_en = 1'b0; wdata = '0;
        rd(ra(3, 'h10), d); check("R10 event wins over same-cycle ack", d, 32'hD2);
        rd(ra(3, 'h14), d); check("R10 collision count wrapped", d, 32'h0);
        wr(ra(3, 'h08), 32'h0);
        wr(ra(3, 'h20), 32'h80);
    endtask

    task automatic t_single();
        logic [31:0] d;
        wr(ra(1, 'h00), 32'h0);
        wr(ra(1, 'h18), 32'd2);
        wr(ra(1, 'h0C), 32'h1);
        wr(ra(1, 'h04), 32'h0);
        ticks(1, 2);
        rd(ra(1, 'h10), d); check("R6 R7 single running", d, 32'h32);
        ticks(1, 1);
        rd(ra(1, 'h10), d); check("R6 single expired idle", d, 32'hA1);
        rd(ra(1, 'h14), d); check("R6 count parked at limit", d, 32'h2);
        ticks(1, 3);
        rd(ra(1, 'h14), d); check("R6 no count after expiry", d, 32'h2);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        wr(ra(2, 'h00), 32'h0);
        wr(ra(2, 'h18), 32'hFFFF_FFFF);
        wr(ra(2, 'h0C), 32'h0);
        wr(ra(2, 'h04), 32'h0);
        ticks(2, 255);
        rd(ra(2, 'h14), d); check("R11 count at maximum", d, 32'hFF);
        rd(ra(2, 'h10), d); check("R11 not pending at maximum", d, 32'h12);
        ticks(2, 1);
        rd(ra(2, 'h14), d); check("R11 wrapped to zero", d, 32'h0);
        rd(ra(2, 'h10), d); check("R11 pending after wrap", d, 32'h92);
        ticks(2, 2);
        rd(ra(2, 'h14), d); check("R11 keeps running", d, 32'h2);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_map();
        t_start_stop();
        t_clock_gate();
        t_clear_cmd();
        t_repeat();
        t_single();
        t_wrap();
        finish_run();
    end

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule